// File: doc/BRIEF.md
# Hypervisor Coprocessor Trap Controller

This block owns a 32-bit hypervisor trap-control register and judges every coprocessor system-register access presented to it. Each access is either trapped to the hypervisor, reported as undefined, or allowed to proceed. An access carries the current privilege level, a non-secure flag, a hypervisor-enabled flag, a transfer kind (single or double), the five encoding fields, a direction, write data, and a hint saying whether the access would be undefined with no trap set.

For guest accesses to coprocessor 15, the block picks one trap-enable bit. Single transfers select it by CRn and double transfers select it by CRm, and each kind reports its own syndrome class. The register itself is reached through one fixed single-transfer encoding. It has its own rules that depend on the privilege level.

A request is captured on the clock edge where `req_valid` is high. For one cycle after that, `done` is high and the verdict is presented combinationally from the captured request. An accepted write updates the register on the edge that closes that cycle.

Top module: `hyp_cp_trap_ctrl`

## Requirements
- R1: After reset the register reads as 0 from level 2, and `done`, `trap`, `undef` and `rdata` are all 0 until the first request.
- R2: Only bits 15, 13..5 and 3..0 are writable. Writing 0xFFFFFFFF reads back 0x0000BFEF. Reserved bit 4 can never cause a trap on CRn 4.
- R3: A single transfer with coproc 15 from non-secure level 1, with the hypervisor enabled, traps with class 0x03 when the register bit at index CRn is 1.
- R4: A double transfer with coproc 15 from non-secure level 1, with the hypervisor enabled, traps with class 0x04 when the register bit at index CRm is 1. CRn is ignored for double transfers.
- R5: A matching non-secure level 0 access traps (class 0x03 or 0x04) only when `req_undef_base` is 0. When `req_undef_base` is 1 it reports undefined and does not trap.
- R6: When the selected bit is 0 there is no trap, and `undef` equals `req_undef_base`.
- R7: Secure accesses, accesses with the hypervisor disabled, and accesses with coproc other than 15 never trap through the register.
- R8: The register encoding is single transfer, coproc 15, opc1 4, CRn 1, CRm 1, opc2 3. From level 0 it is undefined. From level 1 it traps with class 0x03 when the access is non-secure, the hypervisor is enabled and bit 1 is set; otherwise it is undefined.
- R9: Level 2 reads and writes the register. Level 3 reads and writes it only when non-secure; a secure level 3 access is undefined and leaves the register unchanged.
- R10: `done` is high exactly in the cycle after `req_valid` was sampled high. A write is used by a request sampled in the very next cycle.
- R11: `trap` and `undef` are never both high. When `done` is low, `trap`, `undef` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access presented this cycle |
| req_el | input | 2 | Privilege level 0..3 |
| req_ns | input | 1 | Non-secure state |
| req_hyp_en | input | 1 | Hypervisor enabled |
| req_double | input | 1 | 1 = double transfer, 0 = single transfer |
| req_write | input | 1 | 1 = write (move to), 0 = read |
| req_coproc | input | 4 | Coprocessor number |
| req_opc1 | input | 3 | opc1 field |
| req_crn | input | 4 | CRn field |
| req_crm | input | 4 | CRm field |
| req_opc2 | input | 3 | opc2 field |
| req_wdata | input | 32 | Write data for the register |
| req_undef_base | input | 1 | Access is undefined when no trap is set |
| trap | output | 1 | Access traps to the hypervisor |
| trap_class | output | 6 | Syndrome class of the trap |
| undef | output | 1 | Access is undefined |
| rdata | output | 32 | Register read data on an accepted read |
| done | output | 1 | Verdict valid this cycle |

## Verification
Two functions can meet in consecutive cycles: a write to the trap register committing, and a guest access judged against that register. The bench issues a level 2 write that sets one bit. In the very next cycle, with no idle gap, it issues a guest access selecting that bit and expects a trap. The same overlap appears when the register's own level 1 access depends on bit 1 of the value being written just before.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

   typedef enum logic [1:0] {
      LVL_USER   = 2'd0,
      LVL_KERNEL = 2'd1,
      LVL_HYP    = 2'd2,
      LVL_MON    = 2'd3
   } hcp_lvl_e;

   typedef struct packed {
      hcp_lvl_e   lvl;
      logic       ns;
      logic       hyp_en;
      logic       dbl;
      logic       wr;
      logic [3:0] coproc;
      logic [2:0] opc1;
      logic [3:0] crn;
      logic [3:0] crm;
      logic [2:0] opc2;
      logic       undef_base;
   } hcp_req_t;

endpackage

// File: rtl/hcp_req_stage.sv
module hcp_req_stage
   import hcp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  hcp_req_t          in_req,
   input  logic [DATA_W-1:0] in_wdata,
   output logic              out_valid,
   output hcp_req_t          out_req,
   output logic [DATA_W-1:0] out_wdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_req   <= '0;
         out_wdata <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_req   <= in_req;
            out_wdata <= in_wdata;
         end
      end
   end

   // R10: every sampled request yields a verdict cycle
   p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

endmodule

// File: rtl/hcp_trap_bits.sv
module hcp_trap_bits #(
   parameter int              DATA_W = 32,
   parameter logic [DATA_W-1:0] WMASK = 32'h0000_BFEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] bits
);

   generate
      if (DATA_W < 16) begin : g_bad_width
         $error("hcp_trap_bits: DATA_W must cover 16 trap indices");
      end
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bits[i] <= 1'b0;
            else if (wr_en)
               bits[i] <= wr_data[i] & WMASK[i];
         end
      end
   endgenerate

   // R9: register holds unless an accepted write occurs
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> bits == $past(bits));

   // R2: reserved positions never change away from zero after a write
   p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (bits & ~WMASK) == '0);

endmodule

// File: rtl/hcp_decide.sv
module hcp_decide
   import hcp_pkg::*;
#(
   parameter int         NSEL        = 16,
   parameter int         CLS_W       = 6,
   parameter logic [3:0] CP_SEL      = 4'hF,
   parameter logic [2:0] SELF_OPC1   = 3'd4,
   parameter logic [3:0] SELF_CRN    = 4'd1,
   parameter logic [3:0] SELF_CRM    = 4'd1,
   parameter logic [2:0] SELF_OPC2   = 3'd3,
   parameter int         SELF_BIT    = 1,
   parameter int         CODE_SINGLE = 3,
   parameter int         CODE_DOUBLE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  hcp_req_t         req,
   input  logic [NSEL-1:0]  tbits,
   output logic             trap,
   output logic             undef,
   output logic [CLS_W-1:0] cls,
   output logic             rd_ok,
   output logic             wr_ok
);

   localparam int IDX_W = $clog2(NSEL);
   localparam logic [CLS_W-1:0] C_SGL = CLS_W'(CODE_SINGLE);
   localparam logic [CLS_W-1:0] C_DBL = CLS_W'(CODE_DOUBLE);

   generate
      if (IDX_W != 4) begin : g_bad_sel
         $error("hcp_decide: NSEL must be 16 for 4-bit selectors");
      end
      if (CODE_SINGLE >= (1 << CLS_W) || CODE_DOUBLE >= (1 << CLS_W)) begin : g_bad_code
         $error("hcp_decide: class codes exceed CLS_W");
      end
      if (SELF_BIT >= NSEL) begin : g_bad_self
         $error("hcp_decide: SELF_BIT out of range");
      end
   endgenerate

   logic             cp_hit;
   logic             self_hit;
   logic             guest_ok;
   logic [IDX_W-1:0] idx;
   logic             sel_bit;
   logic             guest_trap;

   assign cp_hit   = (req.coproc == CP_SEL);
   assign self_hit = cp_hit && !req.dbl && (req.opc1 == SELF_OPC1) &&
                     (req.crn == SELF_CRN) && (req.crm == SELF_CRM) &&
                     (req.opc2 == SELF_OPC2);
   assign guest_ok = req.ns && req.hyp_en;
   assign idx      = req.dbl ? req.crm : req.crn;
   assign sel_bit  = tbits[idx];
   assign guest_trap = cp_hit && guest_ok && sel_bit &&
                       ((req.lvl == LVL_KERNEL) ||
                        ((req.lvl == LVL_USER) && !req.undef_base));

   always_comb begin
      trap  = 1'b0;
      undef = 1'b0;
      cls   = '0;
      rd_ok = 1'b0;
      wr_ok = 1'b0;
      if (valid) begin
         if (self_hit) begin
            unique case (req.lvl)
               LVL_USER:   undef = 1'b1;
               LVL_KERNEL: begin
                  if (guest_ok && tbits[SELF_BIT]) begin
                     trap = 1'b1;
                     cls  = C_SGL;
                  end else begin
                     undef = 1'b1;
                  end
               end
               LVL_HYP: begin
                  rd_ok = !req.wr;
                  wr_ok = req.wr;
               end
               LVL_MON: begin
                  if (req.ns) begin
                     rd_ok = !req.wr;
                     wr_ok = req.wr;
                  end else begin
                     undef = 1'b1;
                  end
               end
               default: undef = 1'b1;
            endcase
         end else if (guest_trap) begin
            trap = 1'b1;
            cls  = req.dbl ? C_DBL : C_SGL;
         end else begin
            undef = req.undef_base;
         end
      end
   end

   // R11: verdicts are mutually exclusive
   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap && undef));
   // R11: nothing is reported outside a verdict cycle
   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> !trap && !undef && !rd_ok && !wr_ok);
   // R7: secure state never traps
   p_secure_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !req.ns |-> !trap);
   // R7: hypervisor disabled never traps
   p_nohyp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !req.hyp_en |-> !trap);
   // R8: level 0 access to the register itself is undefined
   p_user_self_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid && self_hit && req.lvl == LVL_USER |-> undef);
   // R5: a level 0 access already undefined never traps
   p_user_undef_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid && req.lvl == LVL_USER && req.undef_base |-> !trap);

endmodule

// File: rtl/hyp_cp_trap_ctrl.sv
module hyp_cp_trap_ctrl
   import hcp_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter logic [DATA_W-1:0] WMASK       = 32'h0000_BFEF,
   parameter int                CLS_W       = 6,
   parameter int                CODE_SINGLE = 3,
   parameter int                CODE_DOUBLE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_el,
   input  logic              req_ns,
   input  logic              req_hyp_en,
   input  logic              req_double,
   input  logic              req_write,
   input  logic [3:0]        req_coproc,
   input  logic [2:0]        req_opc1,
   input  logic [3:0]        req_crn,
   input  logic [3:0]        req_crm,
   input  logic [2:0]        req_opc2,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_undef_base,
   output logic              trap,
   output logic [CLS_W-1:0]  trap_class,
   output logic              undef,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);

   localparam int NSEL = 16;

   generate
      if (DATA_W < NSEL) begin : g_bad_data
         $error("hyp_cp_trap_ctrl: DATA_W too small");
      end
   endgenerate

   hcp_req_t          in_req;
   hcp_req_t          q_req;
   logic [DATA_W-1:0] q_wdata;
   logic [DATA_W-1:0] tbits;
   logic              rd_ok;
   logic              wr_ok;

   always_comb begin
      in_req.lvl        = hcp_lvl_e'(req_el);
      in_req.ns         = req_ns;
      in_req.hyp_en     = req_hyp_en;
      in_req.dbl        = req_double;
      in_req.wr         = req_write;
      in_req.coproc     = req_coproc;
      in_req.opc1       = req_opc1;
      in_req.crn        = req_crn;
      in_req.crm        = req_crm;
      in_req.opc2       = req_opc2;
      in_req.undef_base = req_undef_base;
   end

   hcp_req_stage #(.DATA_W(DATA_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid),
      .in_req    (in_req),
      .in_wdata  (req_wdata),
      .out_valid (done),
      .out_req   (q_req),
      .out_wdata (q_wdata)
   );

   hcp_trap_bits #(.DATA_W(DATA_W), .WMASK(WMASK)) u_bits (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_data (q_wdata),
      .bits    (tbits)
   );

   hcp_decide #(
      .NSEL        (NSEL),
      .CLS_W       (CLS_W),
      .CODE_SINGLE (CODE_SINGLE),
      .CODE_DOUBLE (CODE_DOUBLE)
   ) u_decide (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (done),
      .req   (q_req),
      .tbits (tbits[NSEL-1:0]),
      .trap  (trap),
      .undef (undef),
      .cls   (trap_class),
      .rd_ok (rd_ok),
      .wr_ok (wr_ok)
   );

   assign rdata = rd_ok ? tbits : '0;

   // R10: a verdict cycle follows every request
   p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> done);
   // R10: no verdict without a request
   p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !done);
   // R11: read data is quiet outside verdict cycles
   p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> rdata == '0);

endmodule

// File: tb/hyp_cp_trap_ctrl_test.sv
`timescale 1ns/1ps
module hyp_cp_trap_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_el = '0;
   logic        req_ns = 1'b0;
   logic        req_hyp_en = 1'b0;
   logic        req_double = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_coproc = '0;
   logic [2:0]  req_opc1 = '0;
   logic [3:0]  req_crn = '0;
   logic [3:0]  req_crm = '0;
   logic [2:0]  req_opc2 = '0;
   logic [31:0] req_wdata = '0;
   logic        req_undef_base = 1'b0;
   logic        trap;
   logic [5:0]  trap_class;
   logic        undef;
   logic [31:0] rdata;
   logic        done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic        o_trap, o_undef;
   logic [5:0]  o_cls;
   logic [31:0] o_rdata;

   always #2.5 clk = ~clk;

   hyp_cp_trap_ctrl uut (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] el, input logic ns, input logic hyp,
                        input logic dbl, input logic wr, input logic [3:0] cp,
                        input logic [2:0] o1, input logic [3:0] crn,
                        input logic [3:0] crm, input logic [2:0] o2,
                        input logic [31:0] wd, input logic ub);
      req_el = el; req_ns = ns; req_hyp_en = hyp; req_double = dbl;
      req_write = wr; req_coproc = cp; req_opc1 = o1; req_crn = crn;
      req_crm = crm; req_opc2 = o2; req_wdata = wd; req_undef_base = ub;
      req_valid = 1'b1;
      @(negedge clk);
      o_trap = trap; o_undef = undef; o_cls = trap_class; o_rdata = rdata;
      chk("R10 done in verdict cycle", {31'd0, done}, 32'd1);
      chk("R11 trap and undef exclusive", {31'd0, trap & undef}, 32'd0);
      req_valid = 1'b0;
   endtask

   task automatic reg_acc(input logic [1:0] el, input logic ns, input logic wr,
                          input logic [31:0] wd);
      issue(el, ns, 1'b1, 1'b0, wr, 4'hF, 3'd4, 4'd1, 4'd1, 3'd3, wd, 1'b0);
   endtask

   task automatic guest(input logic [1:0] el, input logic ns, input logic hyp,
                        input logic dbl, input logic [3:0] crn,
                        input logic [3:0] crm, input logic ub);
      issue(el, ns, hyp, dbl, 1'b0, 4'hF, 3'd0, crn, crm, 3'd0, 32'd0, ub);
   endtask

   task automatic t_reset;
      chk("R1 done after reset", {31'd0, done}, 32'd0);
      chk("R1 trap after reset", {31'd0, trap}, 32'd0);
      chk("R1 undef after reset", {31'd0, undef}, 32'd0);
      chk("R1 rdata after reset", rdata, 32'd0);
      reg_acc(2'd2, 1'b1, 1'b0, 32'd0);
      chk("R1 reset value", o_rdata, 32'd0);
   endtask

   task automatic t_reserved;
      reg_acc(2'd2, 1'b1, 1'b1, 32'hFFFF_FFFF);
      reg_acc(2'd2, 1'b1, 1'b0, 32'd0);
      chk("R2 writable mask", o_rdata, 32'h0000_BFEF);
      guest(2'd1, 1'b1, 1'b1, 1'b0, 4'd4, 4'd0, 1'b0);
      chk("R2 reserved bit4 no trap", {31'd0, o_trap}, 32'd0);
      guest(2'd1, 1'b1, 1'b1, 1'b0, 4'd14, 4'd0, 1'b0);
      chk("R2 reserved bit14 no trap", {31'd0, o_trap}, 32'd0);
      guest(2'd1, 1'b1, 1'b1, 1'b0, 4'd15, 4'd0, 1'b0);
      chk("R2 bit15 traps", {31'd0, o_trap}, 32'd1);
      reg_acc(2'd2, 1'b1, 1'b1, 32'd0);
      reg_acc(2'd2, 1'b1, 1'b0, 32'd0);
      chk("R2 cleared", o_rdata, 32'd0);
   endtask

   task automatic t_single;
      reg_acc(2'd2, 1'b1, 1'b1, 32'h0000_0080);
      guest(2'd1, 1'b1, 1'b1, 1'b0, 4'd7, 4'd0, 1'b0);
      chk("R3 single trap", {31'd0, o_trap}, 32'd1);
      chk("R3 single class", {26'd0, o_cls}, 32'h3);
      guest(2'd1, 1'b1, 1'b1, 1'b0, 4'd6, 4'd7, 1'b0);
      chk("R6 clear bit no trap", {31'd0, o_trap}, 32'd0);
      chk("R6 undef follows hint 0", {31'd0, o_undef}, 32'd0);
      guest(2'd1, 1'b1, 1'b1, 1'b0, 4'd6, 4'd0, 1'b1);
      chk("R6 undef follows hint 1", {31'd0, o_undef}, 32'd1);
   endtask

   task automatic t_double;
      guest(2'd1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd7, 1'b0);
      chk("R4 double trap", {31'd0, o_trap}, 32'd1);
      chk("R4 double class", {26'd0, o_cls}, 32'h4);
      guest(2'd1, 1'b1, 1'b1, 1'b1, 4'd7, 4'd2, 1'b0);
      chk("R4 crn ignored for double", {31'd0, o_trap}, 32'd0);
   endtask

   task automatic t_user;
      guest(2'd0, 1'b1, 1'b1, 1'b0, 4'd7, 4'd0, 1'b0);
      chk("R5 level0 traps", {31'd0, o_trap}, 32'd1);
      chk("R5 level0 class", {26'd0, o_cls}, 32'h3);
      guest(2'd0, 1'b1, 1'b1, 1'b1, 4'd0, 4'd7, 1'b1);
      chk("R5 level0 undef no trap", {31'd0, o_trap}, 32'd0);
      chk("R5 level0 undef reported", {31'd0, o_undef}, 32'd1);
   endtask

   task automatic t_secure;
      guest(2'd1, 1'b0, 1'b1, 1'b0, 4'd7, 4'd0, 1'b0);
      chk("R7 secure no trap", {31'd0, o_trap}, 32'd0);
      guest(2'd1, 1'b1, 1'b0, 1'b0, 4'd7, 4'd0, 1'b0);
      chk("R7 hyp off no trap", {31'd0, o_trap}, 32'd0);
      issue(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 4'hE, 3'd0, 4'd7, 4'd0, 3'd0, 32'd0, 1'b0);
      chk("R7 other coproc no trap", {31'd0, o_trap}, 32'd0);
   endtask

   task automatic t_self;
      reg_acc(2'd0, 1'b1, 1'b0, 32'd0);
      chk("R8 level0 self undef", {31'd0, o_undef}, 32'd1);
      reg_acc(2'd1, 1'b1, 1'b0, 32'd0);
      chk("R8 level1 self undef when bit1 clear", {31'd0, o_undef}, 32'd1);
      reg_acc(2'd2, 1'b1, 1'b1, 32'h0000_0002);
      reg_acc(2'd1, 1'b1, 1'b0, 32'd0);
      chk("R8 level1 self trap", {31'd0, o_trap}, 32'd1);
      chk("R8 level1 self class", {26'd0, o_cls}, 32'h3);
      issue(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 3'd4, 4'd1, 4'd1, 3'd3, 32'd0, 1'b0);
      chk("R8 level1 self hyp off undef", {31'd0, o_undef}, 32'd1);
   endtask

   task automatic t_monitor;
      reg_acc(2'd3, 1'b0, 1'b1, 32'h0000_FFFF);
      chk("R9 secure level3 undef", {31'd0, o_undef}, 32'd1);
      reg_acc(2'd2, 1'b1, 1'b0, 32'd0);
      chk("R9 secure level3 no write", o_rdata, 32'h0000_0002);
      reg_acc(2'd3, 1'b1, 1'b1, 32'h0000_0020);
      chk("R9 ns level3 write ok", {31'd0, o_undef}, 32'd0);
      reg_acc(2'd3, 1'b1, 1'b0, 32'd0);
      chk("R9 ns level3 read", o_rdata, 32'h0000_0020);
   endtask

   task automatic t_back2back;
      reg_acc(2'd2, 1'b1, 1'b1, 32'h0000_0200);
      guest(2'd1, 1'b1, 1'b1, 1'b0, 4'd9, 4'd0, 1'b0);
      chk("R10 write seen next cycle", {31'd0, o_trap}, 32'd1);
      @(negedge clk);
      chk("R10 done drops", {31'd0, done}, 32'd0);
      chk("R11 idle trap", {31'd0, trap}, 32'd0);
      chk("R11 idle undef", {31'd0, undef}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reserved();
      t_single();
      t_double();
      t_user();
      t_secure();
      t_self();
      t_monitor();
      t_back2back();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule